// File: doc/BRIEF.md
# Almost-Flag Threshold Register Sequencer

This block keeps the two thresholds that a FIFO's almost-empty and almost-full flag logic compares against: the empty threshold n and the full threshold m. Each threshold is split into an 8-bit low byte and a high part that is only as wide as the FIFO depth needs beyond eight bits. Software or a host state machine reaches the four pieces without an address. A single cyclic selector steps through them on each access and keeps its place between bursts.

Loads use the write clock and the FIFO input bus. Readback uses the read clock and drives the selected piece onto a 9-bit output bus. Both paths are gated by the active-low load control. The function is available only when the load control is held low while reset is applied. If the load control is high during reset, that pin acts as an ordinary second write enable for the FIFO, and the thresholds stay at their defaults. The assembled thresholds go straight to the flag logic.

Top module: `ofs_load_ctrl`

## Requirements
- R1: While reset is low across a clock edge, both thresholds become 7 (low byte 07h, high part 0), the readback bus becomes 0, and both selectors return to the empty-threshold low byte.
- R2: The level of `ld_n` sampled during reset picks the mode. Low selects programmable mode. High selects two-enable mode, in which every load and readback attempt is ignored: the thresholds stay 7 and the readback bus stays 0.
- R3: In programmable mode, on a rising `wr_clk` edge with `ld_n` low and `wen1_n` low, the selected piece is written. A low byte takes `din[7:0]`, a high part takes `din[HI_W-1:0]`, and `din[8]` has no effect.
- R4: The selector order is: empty low byte (0), empty high part (1), full low byte (2), full high part (3). The fifth access returns to the empty low byte.
- R5: The write selector advances only on a load. It keeps its position while `ld_n` is high or `wen1_n` is high, so the next load continues the sequence.
- R6: In programmable mode, on a rising `rd_clk` edge with `ld_n`, `ren1_n` and `ren2_n` all low, `dout` takes the selected piece zero-extended to 9 bits. This uses a read-side selector of its own that follows the same order and wraps in the same way.
- R7: `dout` holds its value on any `rd_clk` edge where `ld_n`, `ren1_n` or `ren2_n` is high, and the read selector does not move on such an edge.
- R8: `empty_ofs_o` is the empty high part above the empty low byte, and `full_ofs_o` is built the same way. Both hold steady on every `wr_clk` edge where `ld_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each domain |
| ld_n | input | 1 | Active-low load control; its level during reset selects the mode |
| wen1_n | input | 1 | Active-low write enable for loads |
| din | input | 9 | FIFO input bus, which carries the load data |
| ren1_n | input | 1 | Active-low read enable 1 |
| ren2_n | input | 1 | Active-low read enable 2 |
| dout | output | 9 | Readback bus |
| empty_ofs_o | output | ADDR_W | Assembled empty threshold n |
| full_ofs_o | output | ADDR_W | Assembled full threshold m |

## Verification
The hardest state to reach is a write selector that sits partway through its cycle, after a partial burst, while the read selector is at a different position. The stimulus table loads one piece per burst and raises `ld_n` between bursts. It runs nine loads so that the write selector wraps and ends on the empty high part. Directed steps then hold `wen1_n` high with `ld_n` low, issue a load that must land on the empty high part, and read back all pieces from the read selector's separate start position, including one wrap.

// File: rtl/ofs_ld_pkg.sv
package ofs_ld_pkg;

    localparam int DATA_W = 9;
    localparam int LO_W   = 8;
    localparam logic [LO_W-1:0] DFLT_LO = 8'h07;

    // Fixed access order; the numeric codes are the sequence positions
    typedef enum logic [1:0] {
        SEL_E_LO = 2'd0,
        SEL_E_HI = 2'd1,
        SEL_F_LO = 2'd2,
        SEL_F_HI = 2'd3
    } ofs_sel_e;

    function automatic ofs_sel_e sel_next(input ofs_sel_e cur);
        return ofs_sel_e'(cur + 2'd1);
    endfunction

endpackage

// File: rtl/ofs_wr_path.sv
module ofs_wr_path
    import ofs_ld_pkg::*;
#(
    parameter int HI_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              wen1_n,
    input  logic [DATA_W-1:0] din,
    output logic [LO_W-1:0]   e_lo_o,
    output logic [HI_W-1:0]   e_hi_o,
    output logic [LO_W-1:0]   f_lo_o,
    output logic [HI_W-1:0]   f_hi_o,
    output logic              prog_o,
    output ofs_sel_e          sel_o
);

    typedef struct packed {
        logic            prog;
        ofs_sel_e        sel;
        logic [LO_W-1:0] e_lo;
        logic [HI_W-1:0] e_hi;
        logic [LO_W-1:0] f_lo;
        logic [HI_W-1:0] f_hi;
    } wr_st_t;

    wr_st_t st_d, st_q;
    logic   load;

    assign load = st_q.prog && !ld_n && !wen1_n;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.prog = !ld_n;
            st_d.sel  = SEL_E_LO;
            st_d.e_lo = DFLT_LO;
            st_d.e_hi = '0;
            st_d.f_lo = DFLT_LO;
            st_d.f_hi = '0;
        end else if (load) begin
            case (st_q.sel)
                SEL_E_LO: st_d.e_lo = din[LO_W-1:0];
                SEL_E_HI: st_d.e_hi = din[HI_W-1:0];
                SEL_F_LO: st_d.f_lo = din[LO_W-1:0];
                default:  st_d.f_hi = din[HI_W-1:0];
            endcase
            st_d.sel = sel_next(st_q.sel);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign e_lo_o = st_q.e_lo;
    assign e_hi_o = st_q.e_hi;
    assign f_lo_o = st_q.f_lo;
    assign f_hi_o = st_q.f_hi;
    assign prog_o = st_q.prog;
    assign sel_o  = st_q.sel;

endmodule

// File: rtl/ofs_rd_path.sv
module ofs_rd_path
    import ofs_ld_pkg::*;
#(
    parameter int HI_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              ren1_n,
    input  logic              ren2_n,
    input  logic [LO_W-1:0]   e_lo_i,
    input  logic [HI_W-1:0]   e_hi_i,
    input  logic [LO_W-1:0]   f_lo_i,
    input  logic [HI_W-1:0]   f_hi_i,
    output logic [DATA_W-1:0] dout_o
);

    localparam int LO_PAD = DATA_W - LO_W;
    localparam int HI_PAD = DATA_W - HI_W;

    typedef struct packed {
        logic              prog;
        ofs_sel_e          sel;
        logic [DATA_W-1:0] dout;
    } rd_st_t;

    rd_st_t            st_d, st_q;
    logic              fetch;
    logic [DATA_W-1:0] pick;

    assign fetch = st_q.prog && !ld_n && !ren1_n && !ren2_n;

    always_comb begin
        case (st_q.sel)
            SEL_E_LO: pick = {{LO_PAD{1'b0}}, e_lo_i};
            SEL_E_HI: pick = {{HI_PAD{1'b0}}, e_hi_i};
            SEL_F_LO: pick = {{LO_PAD{1'b0}}, f_lo_i};
            default:  pick = {{HI_PAD{1'b0}}, f_hi_i};
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.prog = !ld_n;
            st_d.sel  = SEL_E_LO;
            st_d.dout = '0;
        end else if (fetch) begin
            st_d.dout = pick;
            st_d.sel  = sel_next(st_q.sel);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout_o = st_q.dout;

endmodule

// File: rtl/ofs_load_ctrl.sv
module ofs_load_ctrl
    import ofs_ld_pkg::*;
#(
    parameter int DEPTH = 8192
) (
    input  logic                            wr_clk,
    input  logic                            rd_clk,
    input  logic                            rst_n,
    input  logic                            ld_n,
    input  logic                            wen1_n,
    input  logic [8:0]                      din,
    input  logic                            ren1_n,
    input  logic                            ren2_n,
    output logic [8:0]                      dout,
    output logic [$clog2(DEPTH)-1:0]        empty_ofs_o,
    output logic [$clog2(DEPTH)-1:0]        full_ofs_o
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int HI_W   = ADDR_W - LO_W;

    logic [LO_W-1:0] e_lo, f_lo;
    logic [HI_W-1:0] e_hi, f_hi;
    logic            wr_prog;
    ofs_sel_e        wr_sel;

    ofs_wr_path #(.HI_W(HI_W)) u_wr (
        .clk    (wr_clk),
        .rst_n  (rst_n),
        .ld_n   (ld_n),
        .wen1_n (wen1_n),
        .din    (din),
        .e_lo_o (e_lo),
        .e_hi_o (e_hi),
        .f_lo_o (f_lo),
        .f_hi_o (f_hi),
        .prog_o (wr_prog),
        .sel_o  (wr_sel)
    );

    ofs_rd_path #(.HI_W(HI_W)) u_rd (
        .clk    (rd_clk),
        .rst_n  (rst_n),
        .ld_n   (ld_n),
        .ren1_n (ren1_n),
        .ren2_n (ren2_n),
        .e_lo_i (e_lo),
        .e_hi_i (e_hi),
        .f_lo_i (f_lo),
        .f_hi_i (f_hi),
        .dout_o (dout)
    );

    assign empty_ofs_o = {e_hi, e_lo};
    assign full_ofs_o  = {f_hi, f_lo};

endmodule

// File: rtl/ofs_load_ctrl_chk.sv
module ofs_load_ctrl_chk
    import ofs_ld_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              rst_n,
    input logic              ld_n,
    input logic              wen1_n,
    input logic [8:0]        din,
    input logic              ren1_n,
    input logic              ren2_n,
    input logic [8:0]        dout,
    input logic [ADDR_W-1:0] empty_ofs_o,
    input logic [ADDR_W-1:0] full_ofs_o,
    input logic              wr_prog,
    input ofs_sel_e          wr_sel
);

    // R8
    ofs_hold_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        ld_n |=> ($stable(empty_ofs_o) && $stable(full_ofs_o)));

    // R2
    dflt_mode_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !wr_prog |-> (empty_ofs_o == ADDR_W'(7) && full_ofs_o == ADDR_W'(7)));

    // R7
    dout_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (ld_n || ren1_n || ren2_n) |=> $stable(dout));

    // R6
    dout_msb_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !dout[8]);

    // R3
    lo_load_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_prog && !ld_n && !wen1_n && wr_sel == SEL_E_LO)
        |=> (empty_ofs_o[7:0] == $past(din[7:0])));

endmodule

bind ofs_load_ctrl ofs_load_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .wr_clk      (wr_clk),
    .rd_clk      (rd_clk),
    .rst_n       (rst_n),
    .ld_n        (ld_n),
    .wen1_n      (wen1_n),
    .din         (din),
    .ren1_n      (ren1_n),
    .ren2_n      (ren2_n),
    .dout        (dout),
    .empty_ofs_o (empty_ofs_o),
    .full_ofs_o  (full_ofs_o),
    .wr_prog     (wr_prog),
    .wr_sel      (wr_sel)
);

// File: tb/ofs_load_ctrl_tb.sv
module ofs_load_ctrl_tb;

    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        rst_n  = 1'b0;
    logic        ld_n   = 1'b0;
    logic        wen1_n = 1'b1;
    logic [8:0]  din    = '0;
    logic        ren1_n = 1'b1;
    logic        ren2_n = 1'b1;
    logic [8:0]  dout;
    logic [12:0] empty_ofs_o, full_ofs_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    ofs_load_ctrl #(.DEPTH(8192)) u_dut (
        .wr_clk      (wr_clk),
        .rd_clk      (rd_clk),
        .rst_n       (rst_n),
        .ld_n        (ld_n),
        .wen1_n      (wen1_n),
        .din         (din),
        .ren1_n      (ren1_n),
        .ren2_n      (ren2_n),
        .dout        (dout),
        .empty_ofs_o (empty_ofs_o),
        .full_ofs_o  (full_ofs_o)
    );

    always #5 wr_clk = ~wr_clk;
    initial begin
        #2;
        forever #5 rd_clk = ~rd_clk;
    end

    typedef struct packed {
        logic [8:0]  d;
        logic [12:0] e;
        logic [12:0] f;
    } vec_t;

    // one load per burst; expected thresholds after each (high part is 5 bits)
    localparam vec_t VECS [9] = '{
        '{9'h1AB, 13'h00AB, 13'h0007},
        '{9'h0FF, 13'h1FAB, 13'h0007},
        '{9'h034, 13'h1FAB, 13'h0034},
        '{9'h0E2, 13'h1FAB, 13'h0234},
        '{9'h011, 13'h1F11, 13'h0234},
        '{9'h000, 13'h0011, 13'h0234},
        '{9'h1C8, 13'h0011, 13'h02C8},
        '{9'h003, 13'h0011, 13'h03C8},
        '{9'h055, 13'h0055, 13'h03C8}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic prog);
        rst_n  = 1'b0;
        ld_n   = !prog;
        wen1_n = 1'b1;
        ren1_n = 1'b1;
        ren2_n = 1'b1;
        repeat (3) @(posedge wr_clk);
        #1;
        rst_n = 1'b1;
        ld_n  = 1'b1;
    endtask

    task automatic wr_one(input logic [8:0] d);
        @(posedge wr_clk);
        #1;
        ld_n = 1'b0; wen1_n = 1'b0; din = d;
        @(posedge wr_clk);
        #1;
        wen1_n = 1'b1; ld_n = 1'b1;
    endtask

    task automatic rd_one(input string req, input logic [8:0] exp);
        @(posedge rd_clk);
        #1;
        ld_n = 1'b0; ren1_n = 1'b0; ren2_n = 1'b0;
        @(posedge rd_clk);
        #1;
        ren1_n = 1'b1; ren2_n = 1'b1; ld_n = 1'b1;
        check(req, 32'(dout), 32'(exp));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1 reset state
        do_reset(1'b1);
        @(posedge wr_clk); #1;
        check("R1 empty", 32'(empty_ofs_o), 32'h7);
        check("R1 full", 32'(full_ofs_o), 32'h7);
        check("R1 dout", 32'(dout), 32'h0);

        // R3 R4 R5 table walk, ld_n raised between loads
        for (int i = 0; i < 9; i++) begin
            wr_one(VECS[i].d);
            check("R3 R4 empty", 32'(empty_ofs_o), 32'(VECS[i].e));
            check("R4 R5 full", 32'(full_ofs_o), 32'(VECS[i].f));
        end

        // R8 idle with ld_n high and new data: thresholds hold
        din = 9'h1EE; wen1_n = 1'b0;
        repeat (3) @(posedge wr_clk);
        #1; wen1_n = 1'b1;
        check("R8 empty", 32'(empty_ofs_o), 32'h0055);
        check("R8 full", 32'(full_ofs_o), 32'h03C8);

        // R5 ld_n low, wen1_n high: no load, selector stays at empty high part
        ld_n = 1'b0; din = 9'h0AA;
        repeat (2) @(posedge wr_clk);
        #1; ld_n = 1'b1;
        check("R5 no load", 32'(empty_ofs_o), 32'h0055);
        wr_one(9'h00A);
        check("R5 continue", 32'(empty_ofs_o), 32'h0A55);
        check("R5 full kept", 32'(full_ofs_o), 32'h03C8);

        // R6 readback from separate selector, with wrap
        rd_one("R6 e lo", 9'h055);
        rd_one("R6 e hi", 9'h00A);
        rd_one("R6 f lo", 9'h0C8);
        rd_one("R6 f hi", 9'h003);
        rd_one("R6 wrap", 9'h055);

        // R7 one enable high, then ld_n high: dout holds, selector stays
        @(posedge rd_clk); #1;
        ld_n = 1'b0; ren1_n = 1'b0; ren2_n = 1'b1;
        repeat (2) @(posedge rd_clk);
        #1;
        check("R7 ren2 high", 32'(dout), 32'h055);
        ld_n = 1'b1; ren2_n = 1'b0;
        repeat (2) @(posedge rd_clk);
        #1; ren1_n = 1'b1; ren2_n = 1'b1;
        check("R7 ld high", 32'(dout), 32'h055);
        rd_one("R7 selector held", 9'h00A);

        // R1 reset clears selectors
        do_reset(1'b1);
        @(posedge rd_clk); #1;
        check("R1 dout cleared", 32'(dout), 32'h0);
        wr_one(9'h042);
        check("R1 selector restart", 32'(empty_ofs_o), 32'h0042);
        rd_one("R1 read selector restart", 9'h042);

        // R2 two-enable mode: loads and readback ignored
        do_reset(1'b0);
        wr_one(9'h01F);
        wr_one(9'h01F);
        check("R2 empty default", 32'(empty_ofs_o), 32'h7);
        check("R2 full default", 32'(full_ofs_o), 32'h7);
        rd_one("R2 no readback", 9'h000);

        finish_run();
    end

endmodule